// File: doc/BRIEF.md
# Programmable Card Clock Divider

This block generates the clock sent to a smart card. It produces a fully registered output whose half-period lasts 1, 2, 4 or 8 cycles of the core clock. The output may also be parked at a fixed high or low level. The core clock runs at twice the rate of the reference card clock. Ratio 1 therefore reproduces the reference rate, and the higher ratios divide it by 2, 4 or 8. The output never passes through a gate or a multiplexer driven by a clock.

A host sets the block up through a short access framed by an active-low chip select. The access counts as a programming access only if the program-select input is low when chip select falls. That mode is held internally, so program-select may return high before the access ends. On the core clock edge where chip select is first seen high again, two operation pins and two data pins are captured. Each command carries a card-supply selection (3 V or 5 V) together with its clock setting. The new setting reaches the output only at the end of a half-period. No shortened high or low phase is ever produced. When the clock restarts from a parked level, the divider counter begins again from zero.

Top module: `card_clk_div`

## Requirements
- R1: A run command sets the half-period to 2^k core cycles, where k = {dat_io, dat_rst} (0→1, 1→2, 2→4, 3→8 cycles, so the output period is 2, 4, 8 or 16 cycles).
- R2: A stop command (op pins {sel_a1, sel_a0} = 2'b10) parks card_clk at the level given by dat_rst. The level is held for as long as no other command is loaded.
- R3: Op 2'b00 runs with vsel_5v = 0 and op 2'b01 runs with vsel_5v = 1. A stop sets vsel_5v from dat_io. vsel_5v changes on the capture edge.
- R4: An access programs the block only if prog_n is low on the clock edge where cs_n is first seen low. Releasing prog_n high later in the same access does not cancel it.
- R5: Pin values are captured on the core clock edge where cs_n is first seen high after being low.
- R6: Nothing is loaded in three cases: pins or prog_n change while cs_n stays high; the access was not in programming mode; or the op code is 2'b11. card_clk and vsel_5v keep their behaviour.
- R7: While running, card_clk changes only at the end of a full half-period. A ratio change or stop request waits for that point, and every phase after the change has the new length.
- R8: On leaving stop the counter restarts from zero. The first output change comes half+1 negative edges after the negative edge on which cs_n was driven high, counted from the following one.
- R9: After reset card_clk is 0, vsel_5v is 0 and the clock is parked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the reference card clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select framing an access |
| prog_n | input | 1 | Low at chip select fall selects programming mode |
| sel_a0 | input | 1 | Op code bit 0 |
| sel_a1 | input | 1 | Op code bit 1 |
| dat_io | input | 1 | Data bit: ratio MSB, or supply select on stop |
| dat_rst | input | 1 | Data bit: ratio LSB, or park level on stop |
| card_clk | output | 1 | Card clock output |
| vsel_5v | output | 1 | Card supply select, 1 = 5 V, 0 = 3 V |

## Verification
The bench builds the block with the package defaults: a 2-bit ratio field and a 3-bit counter. With these values every ratio's half-period is at most 8 cycles, so each ratio, both park levels and every transition between them fits in a window of a few dozen cycles. The small counter also lets seeded random command sequences visit each ratio-to-ratio change, each stop-to-run restart and the ignored-access cases many times. The phase lengths are measured directly at the output.

// File: rtl/ccd_pkg.sv
package ccd_pkg;
  localparam int SEL_W = 2;
  localparam int CNT_W = (1 << SEL_W) - 1;

  typedef enum logic [1:0] {
    OP_RUN_3V = 2'b00,
    OP_RUN_5V = 2'b01,
    OP_STOP   = 2'b10,
    OP_NONE   = 2'b11
  } op_e;

  typedef struct packed {
    logic             run;
    logic [SEL_W-1:0] sel;
    logic             lvl;
  } clk_cfg_t;

  // last counter value of a half-period for a given ratio code
  function automatic logic [CNT_W-1:0] last_count(input logic [SEL_W-1:0] sel);
    int unsigned span;
    span = 32'd1 << sel;
    return CNT_W'(span - 1);
  endfunction
endpackage

// File: rtl/ccd_prog_if.sv
module ccd_prog_if
  import ccd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       prog_n,
  input  logic [1:0] op_pins,
  input  logic       d_hi,
  input  logic       d_lo,
  output clk_cfg_t   cfg_q,
  output logic       vsel_q,
  output logic       cs_q,
  output logic       load_evt
);
  logic prog_mode_q;
  logic cs_fall;
  logic cs_rise;
  op_e  op;

  assign cs_fall  = cs_q & ~cs_n;
  assign cs_rise  = ~cs_q & cs_n;
  assign op       = op_e'(op_pins);
  assign load_evt = cs_rise & prog_mode_q & (op != OP_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q        <= 1'b1;
      prog_mode_q <= 1'b0;
      cfg_q       <= '{run: 1'b0, sel: '1, lvl: 1'b0};
      vsel_q      <= 1'b0;
    end else begin
      cs_q <= cs_n;
      if (cs_fall)      prog_mode_q <= ~prog_n;
      else if (cs_rise) prog_mode_q <= 1'b0;
      if (load_evt) begin
        case (op)
          OP_RUN_3V: begin
            cfg_q.run <= 1'b1;
            cfg_q.sel <= SEL_W'({d_hi, d_lo});
            vsel_q    <= 1'b0;
          end
          OP_RUN_5V: begin
            cfg_q.run <= 1'b1;
            cfg_q.sel <= SEL_W'({d_hi, d_lo});
            vsel_q    <= 1'b1;
          end
          OP_STOP: begin
            cfg_q.run <= 1'b0;
            cfg_q.lvl <= d_lo;
            vsel_q    <= d_hi;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ccd_clk_gen.sv
module ccd_clk_gen
  import ccd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  clk_cfg_t         cfg,
  output logic             card_clk,
  output logic             run_q,
  output logic             boundary,
  output logic             start_evt,
  output logic [CNT_W-1:0] cnt_q
);
  logic [SEL_W-1:0] sel_q;

  assign boundary  = run_q && (cnt_q == last_count(sel_q));
  assign start_evt = !run_q && cfg.run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      sel_q    <= '1;
      cnt_q    <= '0;
      card_clk <= 1'b0;
    end else if (start_evt) begin
      run_q <= 1'b1;
      sel_q <= cfg.sel;
      cnt_q <= '0;
    end else if (!run_q) begin
      card_clk <= cfg.lvl;
    end else if (boundary) begin
      cnt_q <= '0;
      if (cfg.run) begin
        card_clk <= ~card_clk;
        sel_q    <= cfg.sel;
      end else begin
        run_q    <= 1'b0;
        card_clk <= cfg.lvl;
      end
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/card_clk_div.sv
module card_clk_div
  import ccd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic prog_n,
  input  logic sel_a0,
  input  logic sel_a1,
  input  logic dat_io,
  input  logic dat_rst,
  output logic card_clk,
  output logic vsel_5v
);
  clk_cfg_t         cfg;
  logic             cs_q;
  logic             load_evt;
  logic             run_q;
  logic             boundary;
  logic             start_evt;
  logic [CNT_W-1:0] cnt_q;

  ccd_prog_if u_prog (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .prog_n   (prog_n),
    .op_pins  ({sel_a1, sel_a0}),
    .d_hi     (dat_io),
    .d_lo     (dat_rst),
    .cfg_q    (cfg),
    .vsel_q   (vsel_5v),
    .cs_q     (cs_q),
    .load_evt (load_evt)
  );

  ccd_clk_gen u_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg       (cfg),
    .card_clk  (card_clk),
    .run_q     (run_q),
    .boundary  (boundary),
    .start_evt (start_evt),
    .cnt_q     (cnt_q)
  );
endmodule

// File: rtl/card_clk_div_chk.sv
module card_clk_div_chk
  import ccd_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             cs_q,
  input logic             load_evt,
  input clk_cfg_t         cfg,
  input logic             run_q,
  input logic             boundary,
  input logic             start_evt,
  input logic [CNT_W-1:0] cnt_q,
  input logic             card_clk,
  input logic             vsel_5v
);
  assert_park_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !cfg.run && card_clk == cfg.lvl && !load_evt) |=> $stable(card_clk));

  assert_idle_pins_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && cs_q) |=> ($stable(vsel_5v) && $stable(cfg)));

  assert_change_at_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !boundary) |=> $stable(card_clk));

  assert_restart_from_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (run_q && cnt_q == '0 && $stable(card_clk)));
endmodule

bind card_clk_div card_clk_div_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .cs_q      (cs_q),
  .load_evt  (load_evt),
  .cfg       (cfg),
  .run_q     (run_q),
  .boundary  (boundary),
  .start_evt (start_evt),
  .cnt_q     (cnt_q),
  .card_clk  (card_clk),
  .vsel_5v   (vsel_5v)
);

// File: tb/card_clk_div_bench.sv
module card_clk_div_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, prog_n = 1'b1, sel_a0 = 1'b0, sel_a1 = 1'b0;
  logic dat_io = 1'b0, dat_rst = 1'b0;
  logic card_clk, vsel_5v;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  bit     m_run = 1'b0;
  int     m_sel = 3;
  bit     m_lvl = 1'b0;
  bit     m_vsel = 1'b0;

  always #5 clk = ~clk;

  card_clk_div u_card_clk_div (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .prog_n(prog_n),
    .sel_a0(sel_a0), .sel_a1(sel_a1), .dat_io(dat_io), .dat_rst(dat_rst),
    .card_clk(card_clk), .vsel_5v(vsel_5v)
  );

  function automatic int half_cycles(input int sel);
    case (sel)
      0: return 1;
      1: return 2;
      2: return 4;
      default: return 8;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic scramble();
    sel_a0 = 1'($urandom); sel_a1 = 1'($urandom);
    dat_io = 1'($urandom); dat_rst = 1'($urandom);
  endtask

  // one access; ends on the negedge after the capture edge
  task automatic access(input bit [1:0] op, input bit d1, input bit d0,
                        input bit prog, input bit release_early);
    @(negedge clk);
    prog_n = ~prog; cs_n = 1'b0; scramble();
    @(negedge clk);
    if (release_early) prog_n = 1'b1;
    sel_a1 = op[1]; sel_a0 = op[0]; dat_io = d1; dat_rst = d0;
    @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
    scramble(); prog_n = 1'($urandom);
  endtask

  task automatic wait_change(output int n);
    logic start;
    start = card_clk;
    n = 0;
    while (n < 64) begin
      @(negedge clk);
      n++;
      if (card_clk !== start) break;
    end
  endtask

  task automatic hold_check(input bit lvl, input int cyc, input string req);
    int bad = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (card_clk !== lvl) bad++;
    end
    check(bad == 0, req, bad, 0);
  endtask

  task automatic phases_check(input int sel, input string req);
    int n;
    wait_change(n);
    wait_change(n);
    check(n == half_cycles(sel), req, n, half_cycles(sel));
    wait_change(n);
    check(n == half_cycles(sel), req, n, half_cycles(sel));
  endtask

  // apply a command to the model and check the block
  task automatic command(input bit [1:0] op, input bit d1, input bit d0);
    bit was_run;
    int n;
    was_run = m_run;
    access(op, d1, d0, 1'b1, 1'($urandom));
    if (op == 2'b00 || op == 2'b01) begin
      m_run = 1'b1; m_sel = {d1, d0}; m_vsel = op[0];
    end else if (op == 2'b10) begin
      m_run = 1'b0; m_lvl = d0; m_vsel = d1;
    end
    check(vsel_5v === m_vsel, "R3 supply select", vsel_5v, m_vsel);
    if (m_run && !was_run) begin
      wait_change(n);
      check(n == half_cycles(m_sel) + 1, "R8 restart delay", n, half_cycles(m_sel) + 1);
      phases_check(m_sel, "R1 ratio after restart");
    end else if (m_run) begin
      phases_check(m_sel, "R7 phases after change");
    end else begin
      repeat (20) @(negedge clk);
      check(card_clk === m_lvl, "R2 park level", card_clk, m_lvl);
      hold_check(m_lvl, 10, "R2 park held");
    end
  endtask

  initial begin
    int n;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(card_clk === 1'b0, "R9 reset clock low", card_clk, 0);
    check(vsel_5v === 1'b0, "R9 reset supply 3V", vsel_5v, 0);
    hold_check(1'b0, 12, "R9 parked after reset");

    // R1 R8: restart from park at ratio code 2
    command(2'b00, 1'b1, 1'b0);
    // R3 R1: 5V, ratio code 0
    command(2'b01, 1'b0, 1'b0);
    // R7: ratio 1 -> 8 while running
    command(2'b00, 1'b1, 1'b1);
    // R4: stop high with prog_n released early
    access(2'b10, 1'b1, 1'b1, 1'b1, 1'b1);
    m_run = 1'b0; m_lvl = 1'b1; m_vsel = 1'b1;
    repeat (20) @(negedge clk);
    check(card_clk === 1'b1, "R4 release early still programs", card_clk, 1);
    check(vsel_5v === 1'b1, "R4 supply with release", vsel_5v, 1);

    // R6: access not in programming mode
    access(2'b00, 1'b0, 1'b1, 1'b0, 1'b0);
    hold_check(1'b1, 20, "R6 normal access ignored");
    check(vsel_5v === 1'b1, "R6 normal access supply", vsel_5v, 1);
    // R6: reserved op code
    access(2'b11, 1'b0, 1'b0, 1'b1, 1'b0);
    hold_check(1'b1, 20, "R6 reserved op ignored");
    check(vsel_5v === 1'b1, "R6 reserved op supply", vsel_5v, 1);
    // R6: pins move while chip select high
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      scramble(); prog_n = 1'($urandom);
    end
    check(card_clk === 1'b1 && vsel_5v === 1'b1, "R6 idle pins ignored",
          {card_clk, vsel_5v}, 3);

    // R5: capture on rise; data changed before the rise wins
    @(negedge clk); prog_n = 1'b0; cs_n = 1'b0;
    sel_a1 = 1'b0; sel_a0 = 1'b1; dat_io = 1'b0; dat_rst = 1'b0;
    @(negedge clk); sel_a1 = 1'b1; sel_a0 = 1'b0; dat_io = 1'b0; dat_rst = 1'b0;
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk); scramble();
    m_lvl = 1'b0; m_vsel = 1'b0;
    check(vsel_5v === 1'b0, "R5 value at rising chip select", vsel_5v, 0);
    repeat (5) @(negedge clk);
    check(card_clk === 1'b0, "R5 park low captured", card_clk, 0);

    // R8: restart at ratio 8
    command(2'b00, 1'b1, 1'b1);
    // R2: stop low while running
    command(2'b10, 1'b0, 1'b0);

    // random sequence
    for (int k = 0; k < 40; k++) begin
      int r;
      r = $urandom_range(0, 7);
      if (r < 5)
        command({1'b0, 1'($urandom)}, 1'($urandom), 1'($urandom));
      else if (r < 7)
        command(2'b10, 1'($urandom), 1'($urandom));
      else begin
        access(2'b11, 1'($urandom), 1'($urandom), 1'b1, 1'b0);
        check(vsel_5v === m_vsel, "R6 reserved op random", vsel_5v, m_vsel);
        if (m_run) phases_check(m_sel, "R6 reserved keeps ratio");
        else hold_check(m_lvl, 10, "R6 reserved keeps park");
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule